// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Break Handling

This block receives asynchronous serial frames: one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A pulse input marks each base-clock period. One mode input sets the base clock to 16 or 8 times the bit rate, and the receiver uses the matching mid-bit sample point. The first base-clock sample that sees the line low starts the bit timing. The start bit is checked again at its middle, and a short low pulse is dropped as noise. Bytes that pass their checks go into a small receive queue, which the host drains one byte at a time.

The block keeps sticky error flags for a bad stop bit, bad parity and queue overrun. A frame of all zeros whose stop bit is also low puts the block into a break state. In that state the receive engine keeps framing and sampling, but nothing enters the queue. The break state ends once the line has been high for a full bit time and the engine is idle. Bytes are stored again starting with the next start bit. Baud generation is not part of this block.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset the queue is empty (`rd_avail` = 0) and `fer_flag`, `per_flag`, `ovr_flag` and `brk_flag` are all 0.
- R2: With `os_8x` = 0, each bit lasts 16 base ticks. The first tick that sees the line low counts as pulse 1, and each bit is sampled on its 8th pulse. A frame with a high stop bit and correct parity (or parity disabled) stores its eight data bits, received LSB first, into the queue.
- R3: With `os_8x` = 1, each bit lasts 8 base ticks and is sampled on its 4th pulse. Otherwise it behaves as in R2.
- R4: When `par_en` = 1, a parity bit follows bit 7. With `par_odd` = 0 the nine bits carry an even number of ones; with `par_odd` = 1, an odd number. A mismatch sets `per_flag`, and the byte is not stored.
- R5: A stop bit sampled low sets `fer_flag`, and the byte is not stored.
- R6: If the line is high again at the start bit's sample point, the receiver returns to idle. No byte is stored and no flag is set.
- R7: A frame with `fer_flag` set and all eight data bits 0 sets `brk_flag`. While `brk_flag` = 1, no byte is stored, including a frame that completes with a good stop bit. `brk_flag` clears once the line has been high for at least one bit time and no frame is in progress. The next good frame after that is stored.
- R8: A good byte that arrives while the queue holds FIFO_DEPTH bytes is dropped, `ovr_flag` is set, and the stored bytes are kept in order.
- R9: `fer_flag`, `per_flag` and `ovr_flag` stay at 1 until the matching `clr_*` input is pulsed. A new error event wins over a clear in the same cycle.
- R10: While `rx_en` = 0, the line is ignored: nothing is stored and no frame flag is set.
- R11: A `rd_en` pulse while `rd_avail` = 1 removes the oldest byte. That byte appears on `rd_data` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base-clock enable, one pulse per oversample period |
| rxd | input | 1 | Serial receive line (idle high) |
| rx_en | input | 1 | Receiver enable |
| os_8x | input | 1 | 1: 8x oversampling, 0: 16x |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even |
| rd_en | input | 1 | Pop one byte from the queue |
| clr_fer | input | 1 | Clear framing-error flag |
| clr_per | input | 1 | Clear parity-error flag |
| clr_ovr | input | 1 | Clear overrun flag |
| rd_data | output | DW | Byte popped by the previous `rd_en` |
| rd_avail | output | 1 | Queue holds at least one byte |
| fer_flag | output | 1 | Sticky framing error |
| per_flag | output | 1 | Sticky parity error |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Break state active |

## Verification
The assertions assume that `os_8x`, `par_en` and `par_odd` stay constant while a frame is in progress, and that `tick` is a single-cycle pulse. The bench changes configuration only while the line has been idle for at least one bit time. It raises `tick` on every second clock, so the pulse is never longer than one cycle. Every frame the bench sends is aligned to whole bit periods of the chosen mode. The break and noise tests lengthen or shorten the low level at the line, not the tick stream, so the clock relationship the assertions rely on always holds.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} rx_state_t;
  localparam int OSR_HI = 16;
  localparam int OSR_LO = 8;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          os_8x,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          fer,
  output logic          per,
  output logic          busy,
  output logic          quiet
);
  localparam int CW = $clog2(OSR_HI) + 1;
  localparam int IW = $clog2(DW + 3);
  localparam logic [IW-1:0] IDX_DATA_END = IW'(DW);
  localparam logic [IW-1:0] IDX_PAR      = IW'(DW + 1);
  localparam logic [IW-1:0] IDX_STOP_NP  = IW'(DW + 1);
  localparam logic [IW-1:0] IDX_STOP_P   = IW'(DW + 2);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_t     st;
  logic [CW-1:0] cnt, hi_cnt, osr, half;
  logic [IW-1:0] idx, last_idx;
  logic [DW-1:0] sr;
  logic          pbit;

  assign rx_s     = sync_q[1];
  assign osr      = os_8x ? CW'(OSR_LO) : CW'(OSR_HI);
  assign half     = osr >> 1;
  assign last_idx = par_en ? IDX_STOP_P : IDX_STOP_NP;
  assign busy     = (st == S_RUN);
  assign quiet    = (hi_cnt >= osr);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  // run of high samples, used to leave the break state
  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '0;
    else if (tick) begin
      if (!rx_s)              hi_cnt <= '0;
      else if (hi_cnt < osr)  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; sr <= '0; pbit <= 1'b0;
      done <= 1'b0; data <= '0; fer <= 1'b0; per <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st <= S_RUN; cnt <= CW'(1); idx <= '0;
          end
          S_RUN: begin
            if (cnt == osr - 1'b1) begin
              cnt <= '0; idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
            if (cnt == half - 1'b1) begin
              if (idx == '0) begin
                if (rx_s) st <= S_IDLE;
              end else if (idx <= IDX_DATA_END) begin
                sr <= {rx_s, sr[DW-1:1]};
              end else if (idx == IDX_PAR && par_en) begin
                pbit <= rx_s;
              end
              if (idx == last_idx) begin
                st   <= S_IDLE;
                done <= 1'b1;
                data <= sr;
                fer  <= !rx_s;
                per  <= par_en && ((^sr ^ pbit) != par_odd);
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_glitch_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_en && tick && idx == '0 && cnt == half - 1'b1 && rx_s) |=> (st == S_IDLE && !done));
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (st == S_IDLE && !done));
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  assign empty = (count == '0);
  assign full  = (count == CNT_FULL);

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (wr) wptr <= wptr + 1'b1;
      if (rd) rptr <= rptr + 1'b1;
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst) wr |-> !full);
  p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (rst) rd |-> !empty);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          os_8x,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_en,
  input  logic          clr_fer,
  input  logic          clr_per,
  input  logic          clr_ovr,
  output logic [DW-1:0] rd_data,
  output logic          rd_avail,
  output logic          fer_flag,
  output logic          per_flag,
  output logic          ovr_flag,
  output logic          brk_flag
);
  logic          s_done, s_fer, s_per, s_busy, s_quiet;
  logic [DW-1:0] s_data;
  logic          good, push, pop, f_empty, f_full, brk_frame;

  uart_rx_sampler #(.DW(DW)) u_sampler (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .os_8x(os_8x), .par_en(par_en), .par_odd(par_odd),
    .done(s_done), .data(s_data), .fer(s_fer), .per(s_per),
    .busy(s_busy), .quiet(s_quiet)
  );

  assign good      = s_done && !s_fer && !s_per;
  assign brk_frame = s_done && s_fer && (s_data == '0);
  assign push      = good && !brk_flag && !f_full;
  assign pop       = rd_en && !f_empty;
  assign rd_avail  = !f_empty;

  uart_rx_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(push), .wdata(s_data), .rd(pop),
    .rdata(rd_data), .empty(f_empty), .full(f_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fer_flag <= 1'b0; per_flag <= 1'b0; ovr_flag <= 1'b0; brk_flag <= 1'b0;
    end else begin
      fer_flag <= (s_done && s_fer) || (fer_flag && !clr_fer);
      per_flag <= (s_done && s_per) || (per_flag && !clr_per);
      ovr_flag <= (good && !brk_flag && f_full) || (ovr_flag && !clr_ovr);
      if (brk_frame)                brk_flag <= 1'b1;
      else if (s_quiet && !s_busy)  brk_flag <= 1'b0;
    end
  end

  p_brk_holds_queue_r7: assert property (@(posedge clk) disable iff (rst)
    (brk_flag && f_empty && !pop) |=> f_empty);
  p_brk_with_fer_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag) |-> fer_flag);
  p_ovr_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(f_full));
  p_fer_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (fer_flag && !clr_fer) |=> fer_flag);
endmodule

// File: tb/uart_rx_brk_bench.sv
module uart_rx_brk_bench;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rxd = 1'b1, rx_en = 1'b0;
  logic os_8x = 1'b0, par_en = 1'b0, par_odd = 1'b0, rd_en = 1'b0;
  logic clr_fer = 1'b0, clr_per = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rd_data;
  logic rd_avail, fer_flag, per_flag, ovr_flag, brk_flag;
  int checks = 0, errors = 0;
  bit finished = 0;

  uart_rx_brk #(.DW(8), .FIFO_DEPTH(DEPTH)) u_uart_rx_brk (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en),
    .os_8x(os_8x), .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
    .clr_fer(clr_fer), .clr_per(clr_per), .clr_ovr(clr_ovr),
    .rd_data(rd_data), .rd_avail(rd_avail), .fer_flag(fer_flag),
    .per_flag(per_flag), .ovr_flag(ovr_flag), .brk_flag(brk_flag)
  );

  always #2 clk = ~clk;
  always @(negedge clk) tick <= rst ? 1'b0 : ~tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (os_8x ? 8 : 16) * 2;
  endfunction

  task automatic hold(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // stop_ok=0 keeps the stop bit low only just past its sample point
  task automatic send(input logic [7:0] b, input bit stop_ok, input bit bad_par);
    hold(1'b0, bit_clks());
    for (int i = 0; i < 8; i++) hold(b[i], bit_clks());
    if (par_en) hold((^b) ^ par_odd ^ bad_par, bit_clks());
    if (stop_ok) hold(1'b1, bit_clks());
    else begin
      hold(1'b0, ((os_8x ? 4 : 8) + 2) * 2);
      hold(1'b1, bit_clks());
    end
    hold(1'b1, 2 * bit_clks());
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_fer = 1; clr_per = 1; clr_ovr = 1; end
    @(negedge clk) begin clr_fer = 0; clr_per = 0; clr_ovr = 0; end
  endtask

  task automatic recv_ok(input logic [7:0] b, input string req);
    logic [7:0] d;
    send(b, 1'b1, 1'b0);
    check(rd_avail == 1'b1, req, rd_avail, 1);
    pop(d);
    check(d == b, req, d, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_avail == 0, "R1 avail", rd_avail, 0);
    check({fer_flag, per_flag, ovr_flag, brk_flag} == 4'b0, "R1 flags",
          {fer_flag, per_flag, ovr_flag, brk_flag}, 0);
    rx_en = 1'b1;
    hold(1'b1, 64);

    // R2 with R4: 16x mode, parity toggles between even and odd
    os_8x = 0; par_en = 1;
    for (int i = 0; i < 64; i++) begin
      par_odd = i[0];
      recv_ok(8'(i * 4 + 1), "R2/R4 16x parity");
    end
    check(per_flag == 0 && fer_flag == 0, "R4 no error on good parity", per_flag, 0);

    // R3: 8x mode, every byte, no parity
    os_8x = 1; par_en = 0;
    hold(1'b1, 64);
    for (int i = 0; i < 256; i++) recv_ok(8'(i), "R3 8x sweep");

    // R4: wrong parity is flagged and dropped
    os_8x = 0; par_en = 1; par_odd = 0;
    hold(1'b1, 64);
    send(8'h6B, 1'b1, 1'b1);
    check(per_flag == 1, "R4 per set", per_flag, 1);
    check(rd_avail == 0, "R4 byte dropped", rd_avail, 0);
    // R9: flag persists until cleared
    hold(1'b1, 200);
    check(per_flag == 1, "R9 per sticky", per_flag, 1);
    @(negedge clk) clr_per = 1; @(negedge clk) clr_per = 0;
    check(per_flag == 0, "R9 per cleared", per_flag, 0);

    // R5: low stop bit
    par_en = 0;
    send(8'h55, 1'b0, 1'b0);
    check(fer_flag == 1, "R5 fer set", fer_flag, 1);
    check(rd_avail == 0, "R5 byte dropped", rd_avail, 0);
    check(brk_flag == 0, "R5 no break for nonzero data", brk_flag, 0);
    clear_all();
    check(fer_flag == 0, "R9 fer cleared", fer_flag, 0);

    // R6: short low pulse is noise
    hold(1'b0, 6);
    hold(1'b1, 4 * bit_clks());
    check(rd_avail == 0, "R6 glitch no byte", rd_avail, 0);
    check({fer_flag, per_flag} == 2'b0, "R6 glitch no flag", {fer_flag, per_flag}, 0);

    // R7: break, then line high mid-frame, then recovery
    hold(1'b0, 30 * bit_clks() + 7);
    check(brk_flag == 1, "R7 break set", brk_flag, 1);
    check(fer_flag == 1, "R7 fer in break", fer_flag, 1);
    check(rd_avail == 0, "R7 nothing stored in break", rd_avail, 0);
    hold(1'b1, 14 * bit_clks());
    check(rd_avail == 0, "R7 trailing frame suppressed", rd_avail, 0);
    check(brk_flag == 0, "R7 break cleared after idle bit", brk_flag, 0);
    clear_all();
    recv_ok(8'hA5, "R7 resume after break");

    // R8: overrun
    for (int i = 0; i < DEPTH; i++) send(8'(8'h11 * (i + 1)), 1'b1, 1'b0);
    check(ovr_flag == 0, "R8 no ovr at exactly full", ovr_flag, 0);
    send(8'h99, 1'b1, 1'b0);
    check(ovr_flag == 1, "R8 ovr set", ovr_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      check(d == 8'(8'h11 * (i + 1)), "R8/R11 order kept", d, 8'h11 * (i + 1));
    end
    check(rd_avail == 0, "R8 dropped byte absent", rd_avail, 0);
    @(negedge clk) clr_ovr = 1; @(negedge clk) clr_ovr = 0;
    check(ovr_flag == 0, "R9 ovr cleared", ovr_flag, 0);

    // R10: disabled receiver
    rx_en = 0;
    send(8'h3C, 1'b1, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    check(rd_avail == 0, "R10 nothing stored", rd_avail, 0);
    check({fer_flag, per_flag, brk_flag} == 3'b0, "R10 no flags",
          {fer_flag, per_flag, brk_flag}, 0);
    rx_en = 1;
    hold(1'b1, 64);
    recv_ok(8'hC3, "R10 re-enabled");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule